// File: doc/BRIEF.md
# Slot-Rotated Hub Block Mover

The block copies whole groups of 16 longs between a core's local register file and a shared memory. That shared memory is interleaved across 16 access slots, and the slots rotate by one position on every clock. A command carries four things: a direction, a local start address, a memory start address (in longs) and a 4-bit block count. Once it is accepted, the block spends a short fixed setup. It then moves one long on every clock until every block has been copied, and the issuing core stays stalled for that whole time.

The block never waits for slot 0. It starts each 16-long group at the offset that the rotation offers in the first transfer clock, and the offset then wraps modulo 16. Each long is written to the local side at the same wrapped offset, so the copied data keeps its order. When the transfer finishes, a one-cycle done pulse releases the core. The register file and the memory are outside the block: the block drives enables, write strobes and addresses on both sides, and passes the read data of the source side to the write data of the destination side within the same clock.

Top module: `hbm_mover`

## Requirements
- R1: While reset is asserted and right after it, stall and done are low and neither the memory side nor the local side is enabled.
- R2: A command is accepted on a clock edge where cmd_valid is high, stall is low and done is low. After it, stall is high for exactly 2 setup cycles with no access on either side, and the first transfer cycle comes next.
- R3: Each transfer cycle moves exactly one long. A command moves 16 longs per block. Count values 1 to 15 mean that many blocks, and count 0 means 16 blocks (256 longs).
- R4: In the first transfer cycle the group offset equals slot_pos. The offset rises by one each cycle and wraps from 15 to 0. Block b (counting from 0) at offset n uses memory long address mem_base + 16*b + n, taken modulo 2^MEM_AW.
- R5: The local address of each transfer is local_base + 16*b + n, using the same b and n as the memory side, taken modulo 2^LCL_AW.
- R6: With cmd_dir = 0 (memory to local), the memory side reads and the local side writes mem_rdata. With cmd_dir = 1 (local to memory), the local side reads and the memory side writes lcl_rdata. Both sides are enabled in every transfer cycle.
- R7: Stall stays high from the accepting edge through the last transfer cycle. In the cycle after the last transfer, done is high for exactly one cycle with stall low.
- R8: A cmd_valid raised while stall is high is ignored: the transfer that is running keeps its addresses, direction and length, and no extra transfer follows it.
- R9: Outside transfer cycles, neither side is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_pos | input | IDX_W | Current rotating slot position, advances by one per clock |
| cmd_valid | input | 1 | Command request |
| cmd_dir | input | 1 | 0 = memory to local, 1 = local to memory |
| cmd_lcl_base | input | LCL_AW | Local start address |
| cmd_mem_base | input | MEM_AW | Memory start address in longs |
| cmd_count | input | CNT_W | Block count, 0 means 16 |
| stall | output | 1 | Issuing core must hold |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory long address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| lcl_en | output | 1 | Local access this cycle |
| lcl_we | output | 1 | Local write strobe |
| lcl_addr | output | LCL_AW | Local address |
| lcl_wdata | output | DW | Local write data |
| lcl_rdata | input | DW | Local read data, same cycle |

## Verification
The bench issues commands in both directions, with counts of 1, 2, 3 and the 0 encoding. Idle gaps of different lengths come before each command, so the rotation meets each one at a different starting offset, and the wrap from 15 to 0 falls at a different point in each group. One memory base is unaligned and one command runs past the top of both address spaces. This separates addressing from the slot offset from addressing from 0, and it shows whether the block offset is added before or after truncation. Two of the transfers are hit by a second request while stalled, to show that the running command is left untouched and no stray transfer follows.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } hbm_state_e;

  typedef enum logic {
    DIR_TO_LOCAL = 1'b0,
    DIR_TO_HUB   = 1'b1
  } hbm_dir_e;

endpackage

// File: rtl/hbm_seq.sv
module hbm_seq
  import hbm_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] slot_pos,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             accept,
  output logic             xfer,
  output logic             stall,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] blk
);

  localparam int SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  hbm_state_e       state_q, state_d;
  logic [SC_W-1:0]  sc_q, sc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             ctr_en;

  always_comb begin
    state_d = state_q;
    sc_d    = sc_q;
    idx_d   = idx_q;
    beat_d  = beat_q;
    blk_d   = blk_q;
    last_d  = last_q;
    accept  = (state_q == ST_IDLE) && cmd_valid;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          sc_d    = '0;
          last_d  = cmd_count - CNT_W'(1);
        end
      end
      ST_SETUP: begin
        if (sc_q == SC_W'(SETUP_CYC - 1)) begin
          state_d = ST_XFER;
          idx_d   = slot_pos + IDX_W'(1);
          beat_d  = '0;
          blk_d   = '0;
        end else begin
          sc_d = sc_q + SC_W'(1);
        end
      end
      ST_XFER: begin
        idx_d  = idx_q + IDX_W'(1);
        beat_d = beat_q + IDX_W'(1);
        if (beat_q == {IDX_W{1'b1}}) begin
          if (blk_q == last_q) begin
            state_d = ST_DONE;
          end else begin
            blk_d = blk_q + CNT_W'(1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctr_en = (state_q != ST_IDLE) || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q   <= '0;
      idx_q  <= '0;
      beat_q <= '0;
      blk_q  <= '0;
      last_q <= '0;
    end else if (ctr_en) begin
      sc_q   <= sc_d;
      idx_q  <= idx_d;
      beat_q <= beat_d;
      blk_q  <= blk_d;
      last_q <= last_d;
    end
  end

  assign xfer  = (state_q == ST_XFER);
  assign stall = (state_q == ST_SETUP) || (state_q == ST_XFER);
  assign done  = (state_q == ST_DONE);
  assign idx   = idx_q;
  assign blk   = blk_q;

endmodule

// File: rtl/hbm_addr.sv
module hbm_addr #(
  parameter int LCL_AW = 9,
  parameter int MEM_AW = 17,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic [LCL_AW-1:0] lcl_base,
  input  logic [MEM_AW-1:0] mem_base,
  input  logic [CNT_W-1:0]  blk,
  input  logic [IDX_W-1:0]  idx,
  output logic [LCL_AW-1:0] lcl_addr,
  output logic [MEM_AW-1:0] mem_addr
);

  localparam int OFF_W = CNT_W + IDX_W;

  logic [OFF_W-1:0] offs;

  // block number selects the 16-long group, idx the wrapped long within it
  assign offs     = {blk, idx};
  assign mem_addr = mem_base + MEM_AW'(offs);
  assign lcl_addr = lcl_base + LCL_AW'(offs);

endmodule

// File: rtl/hbm_mover.sv
module hbm_mover
  import hbm_pkg::*;
#(
  parameter int LCL_AW    = 9,
  parameter int MEM_AW    = 17,
  parameter int DW        = 32,
  parameter int SLOTS     = 16,
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 2,
  localparam int IDX_W    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  slot_pos,
  input  logic              cmd_valid,
  input  logic              cmd_dir,
  input  logic [LCL_AW-1:0] cmd_lcl_base,
  input  logic [MEM_AW-1:0] cmd_mem_base,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              stall,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              lcl_en,
  output logic              lcl_we,
  output logic [LCL_AW-1:0] lcl_addr,
  output logic [DW-1:0]     lcl_wdata,
  input  logic [DW-1:0]     lcl_rdata
);

  logic             accept;
  logic             xfer;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] blk;

  hbm_dir_e          dir_q;
  logic [LCL_AW-1:0] lbase_q;
  logic [MEM_AW-1:0] mbase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_TO_LOCAL;
      lbase_q <= '0;
      mbase_q <= '0;
    end else if (accept) begin
      dir_q   <= hbm_dir_e'(cmd_dir);
      lbase_q <= cmd_lcl_base;
      mbase_q <= cmd_mem_base;
    end
  end

  hbm_seq #(
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .SETUP_CYC(SETUP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_pos (slot_pos),
    .cmd_valid(cmd_valid),
    .cmd_count(cmd_count),
    .accept   (accept),
    .xfer     (xfer),
    .stall    (stall),
    .done     (done),
    .idx      (idx),
    .blk      (blk)
  );

  hbm_addr #(
    .LCL_AW(LCL_AW),
    .MEM_AW(MEM_AW),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_addr (
    .lcl_base(lbase_q),
    .mem_base(mbase_q),
    .blk     (blk),
    .idx     (idx),
    .lcl_addr(lcl_addr),
    .mem_addr(mem_addr)
  );

  always_comb begin
    mem_en    = xfer;
    lcl_en    = xfer;
    mem_we    = xfer && (dir_q == DIR_TO_HUB);
    lcl_we    = xfer && (dir_q == DIR_TO_LOCAL);
    mem_wdata = mem_we ? lcl_rdata : '0;
    lcl_wdata = lcl_we ? mem_rdata : '0;
  end

endmodule

// File: rtl/hbm_mover_chk.sv
module hbm_mover_chk #(
  parameter int LCL_AW = 9,
  parameter int MEM_AW = 17,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  slot_pos,
  input logic              cmd_valid,
  input logic              cmd_dir,
  input logic [LCL_AW-1:0] cmd_lcl_base,
  input logic [MEM_AW-1:0] cmd_mem_base,
  input logic [CNT_W-1:0]  cmd_count,
  input logic              stall,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              lcl_en,
  input logic              lcl_we,
  input logic [LCL_AW-1:0] lcl_addr
);

  localparam int TOT_W = CNT_W + IDX_W + 1;

  logic              acc;
  logic              dir_q;
  logic [LCL_AW-1:0] lb_q;
  logic [MEM_AW-1:0] mb_q;
  logic [TOT_W-1:0]  beats_q;
  logic [TOT_W-1:0]  exp_q;
  logic [MEM_AW-1:0] m_off;
  logic [LCL_AW-1:0] l_off;

  assign acc   = cmd_valid && !stall && !done;
  assign m_off = mem_addr - mb_q;
  assign l_off = lcl_addr - lb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      lb_q    <= '0;
      mb_q    <= '0;
      beats_q <= '0;
      exp_q   <= '0;
    end else if (acc) begin
      dir_q   <= cmd_dir;
      lb_q    <= cmd_lcl_base;
      mb_q    <= cmd_mem_base;
      beats_q <= '0;
      exp_q   <= ((cmd_count == '0) ? TOT_W'(2 ** CNT_W) : TOT_W'(cmd_count)) << IDX_W;
    end else if (mem_en) begin
      beats_q <= beats_q + TOT_W'(1);
    end
  end

  AST_SETUP_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> !mem_en && !lcl_en); // R2
  AST_SETUP_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |=> !mem_en && !lcl_en); // R2
  AST_BEAT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> beats_q == exp_q); // R3
  AST_MEM_SLOT: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> m_off[IDX_W-1:0] == slot_pos); // R4
  AST_LCL_SLOT: assert property (@(posedge clk) disable iff (!rst_n) lcl_en |-> l_off[IDX_W-1:0] == slot_pos); // R5
  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> lcl_en && (mem_we == dir_q) && (lcl_we == !dir_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n) done |-> !stall && $past(stall)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !stall |-> !mem_en && !lcl_en); // R9

endmodule

bind hbm_mover hbm_mover_chk #(
  .LCL_AW(LCL_AW),
  .MEM_AW(MEM_AW),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_pos    (slot_pos),
  .cmd_valid   (cmd_valid),
  .cmd_dir     (cmd_dir),
  .cmd_lcl_base(cmd_lcl_base),
  .cmd_mem_base(cmd_mem_base),
  .cmd_count   (cmd_count),
  .stall       (stall),
  .done        (done),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .lcl_en      (lcl_en),
  .lcl_we      (lcl_we),
  .lcl_addr    (lcl_addr)
);

// File: tb/hbm_mover_tb.sv
module hbm_mover_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAW = 9;
  localparam int MAW = 12;

  logic            clk;
  logic            rst_n;
  logic [3:0]      slot;
  logic            cmd_valid;
  logic            cmd_dir;
  logic [LAW-1:0]  cmd_lcl_base;
  logic [MAW-1:0]  cmd_mem_base;
  logic [3:0]      cmd_count;
  logic            stall, done;
  logic            mem_en, mem_we, lcl_en, lcl_we;
  logic [MAW-1:0]  mem_addr;
  logic [LAW-1:0]  lcl_addr;
  logic [31:0]     mem_wdata, mem_rdata, lcl_wdata, lcl_rdata;

  logic [31:0] mem_arr [1 << MAW];
  logic [31:0] lcl_arr [1 << LAW];
  logic [31:0] sh_mem  [1 << MAW];
  logic [31:0] sh_lcl  [1 << LAW];

  typedef struct {
    logic           dir;
    logic [MAW-1:0] ma;
    logic [LAW-1:0] la;
    logic [31:0]    data;
  } beat_t;

  beat_t exp_q[$];

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  hbm_mover #(.LCL_AW(LAW), .MEM_AW(MAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_pos(slot),
    .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_lcl_base(cmd_lcl_base),
    .cmd_mem_base(cmd_mem_base), .cmd_count(cmd_count),
    .stall(stall), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .lcl_en(lcl_en), .lcl_we(lcl_we), .lcl_addr(lcl_addr),
    .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= 4'd0;
    else        slot <= slot + 4'd1;
  end

  assign mem_rdata = mem_arr[mem_addr];
  assign lcl_rdata = lcl_arr[lcl_addr];

  always @(posedge clk) begin
    if (mem_en && mem_we) mem_arr[mem_addr] <= mem_wdata;
    if (lcl_en && lcl_we) lcl_arr[lcl_addr] <= lcl_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected beat per active transfer cycle
  always @(negedge clk) begin
    if (rst_n && !finished && (mem_en || lcl_en)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "access with nothing expected", {20'd0, mem_addr}, 32'd0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.ma, "R4", "memory address", {20'd0, mem_addr}, {20'd0, e.ma});
        chk(lcl_addr == e.la, "R5", "local address", {23'd0, lcl_addr}, {23'd0, e.la});
        if (e.dir == 1'b0) begin
          chk(lcl_we && !mem_we && lcl_en && mem_en, "R6", "to-local strobes",
              {30'd0, mem_we, lcl_we}, 32'd1);
          chk(lcl_wdata == e.data, "R6", "to-local data", lcl_wdata, e.data);
        end else begin
          chk(mem_we && !lcl_we && lcl_en && mem_en, "R6", "to-hub strobes",
              {30'd0, mem_we, lcl_we}, 32'd2);
          chk(mem_wdata == e.data, "R6", "to-hub data", mem_wdata, e.data);
        end
      end
    end
  end

  task automatic run_cmd(input logic d, input logic [LAW-1:0] lb, input logic [MAW-1:0] mb,
                         input logic [3:0] c, input bit poke, input int gap);
    logic [3:0]     n0, ix;
    logic [MAW-1:0] ma;
    logic [LAW-1:0] la;
    beat_t          e;
    int             nb;
    bit             sok, qok, fok;
    repeat (gap) @(negedge clk);
    n0 = slot + 4'd3;                 // accept edge + 2 setup cycles
    nb = (c == 4'd0) ? 16 : int'(c);
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < 16; k++) begin
        ix = n0 + 4'(k);
        ma = mb + MAW'(b * 16) + MAW'(ix);
        la = lb + LAW'(b * 16) + LAW'(ix);
        e.dir = d; e.ma = ma; e.la = la;
        if (d == 1'b0) begin
          e.data = sh_mem[ma];
          sh_lcl[la] = e.data;
        end else begin
          e.data = sh_lcl[la];
          sh_mem[ma] = e.data;
        end
        exp_q.push_back(e);
      end
    end
    cmd_valid = 1'b1; cmd_dir = d; cmd_lcl_base = lb; cmd_mem_base = mb; cmd_count = c;
    sok = 1'b1; qok = 1'b1; fok = 1'b0;
    for (int i = 0; i < 2 + 16 * nb; i++) begin
      @(negedge clk);
      if (i == 0) cmd_valid = 1'b0;
      if (poke && i == 4) begin      // R8 stimulus: request while stalled
        cmd_valid = 1'b1; cmd_dir = ~d; cmd_lcl_base = 9'h0AA;
        cmd_mem_base = 12'h555; cmd_count = 4'd5;
      end
      if (poke && i == 5) cmd_valid = 1'b0;
      if (!stall || done) sok = 1'b0;
      if (i < 2 && (mem_en || lcl_en)) qok = 1'b0;
      if (i == 2 && mem_en && lcl_en) fok = 1'b1;
    end
    chk(sok, "R7", "stall held through transfer", 32'(sok), 32'd1);
    chk(qok, "R2", "no access in setup", 32'(qok), 32'd1);
    chk(fok, "R2", "first beat after 2 setup cycles", 32'(fok), 32'd1);
    @(negedge clk);
    chk(done && !stall, "R7", "done pulse with stall low", {30'd0, done, stall}, 32'd2);
    @(negedge clk);
    chk(!done, "R7", "done lasts one cycle", 32'(done), 32'd0);
    chk(exp_q.size() == 0, "R3", "all beats moved", 32'(exp_q.size()), 32'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!stall && !mem_en && !lcl_en, "R8", "no transfer from ignored request",
          {29'd0, stall, mem_en, lcl_en}, 32'd0);
    end
  endtask

  initial begin
    for (int a = 0; a < (1 << MAW); a++) begin
      mem_arr[a] = 32'h5A00_0000 ^ (32'(a) * 32'h0001_9E37);
      sh_mem[a]  = mem_arr[a];
    end
    for (int a = 0; a < (1 << LAW); a++) begin
      lcl_arr[a] = 32'h3C00_0000 ^ (32'(a) * 32'h0000_0101);
      sh_lcl[a]  = lcl_arr[a];
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dir = 1'b0;
    cmd_lcl_base = '0; cmd_mem_base = '0; cmd_count = '0;
    repeat (3) @(negedge clk);
    chk(!stall && !done && !mem_en && !lcl_en, "R1", "outputs in reset",
        {28'd0, stall, done, mem_en, lcl_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !done && !mem_en && !lcl_en, "R1", "outputs after reset",
        {28'd0, stall, done, mem_en, lcl_en}, 32'd0);

    run_cmd(1'b0, 9'h000, 12'h040, 4'd1, 1'b0, 2);   // R3 single block
    run_cmd(1'b1, 9'h105, 12'h7F3, 4'd2, 1'b0, 5);   // R4 unaligned base
    run_cmd(1'b0, 9'h1F0, 12'hFF8, 4'd3, 1'b1, 7);   // R5 wrap, R8
    run_cmd(1'b0, 9'h000, 12'h200, 4'd0, 1'b0, 1);   // R3 count 0 = 16 blocks
    run_cmd(1'b1, 9'h080, 12'hA00, 4'd1, 1'b1, 10);  // R8 while writing

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!mem_en && !lcl_en && !stall, "R9", "quiet when idle",
          {29'd0, stall, mem_en, lcl_en}, 32'd0);
    end
    begin
      int bad_m, bad_l;
      bad_m = 0; bad_l = 0;
      for (int a = 0; a < (1 << MAW); a++) if (mem_arr[a] !== sh_mem[a]) bad_m++;
      for (int a = 0; a < (1 << LAW); a++) if (lcl_arr[a] !== sh_lcl[a]) bad_l++;
      chk(bad_m == 0, "R6", "final memory contents", 32'(bad_m), 32'd0);
      chk(bad_l == 0, "R6", "final local contents", 32'(bad_l), 32'd0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule